// File: doc/BRIEF.md
# Timestamp-Scheduled Multi-Queue Flip Ring

This block keeps five ring buffers of flip entries for one display pipe in a single shared entry RAM. Software writes entry words straight into that RAM. It then publishes new tail pointers for every queue with one write to a packed tail register. The engine runs a free-running timestamp counter. It checks the presentation timestamp held in the oldest entry of each queue, and when that entry is due it hands a command descriptor to an execution port. The descriptor holds a buffer head address, an engine number, a size in 64-byte units and an interrupt flag. Once the execution port reports completion, the engine advances that queue's head pointer.

There are three plane queues of sixteen 4-word entries and one general queue of eight 6-word entries. A general entry can carry a second descriptor. A fifth queue, the fast queue, has eight 6-word entries; it accepts entries and tail updates but never dispatches. Software uses a preempt bit and the busy status to update queues safely. A wake command makes the engine scan at once instead of waiting for its periodic poll.

Top module: `flipq_engine`

## Requirements
- R1: After reset the control bits, all heads, all tails, the full flags, busy and exec_req are zero.
- R2: A tail write (csr_sel=1) loads each tail from its field of csr_wdata: plane 0 bits [3:0], plane 1 [7:4], plane 2 [11:8], general [14:12], fast [17:15]. It changes no head. heads_o and tails_o use the same field layout.
- R3: full_o[q] is 1 exactly when (tail − head) mod N equals N − 1, where N is 16 for a plane queue and 8 for the general and fast queues. Bit q follows the queue order plane 0, plane 1, plane 2, general, fast.
- R4: Each queue's entry q sits at word base + q·E, where the bases are 0x008, 0x108 and 0x208 for the planes, 0x308 for general and 0x3C8 for fast, and E is 4 or 6. Word 0 holds the PTS and word 2 the control word: bit 31 is the interrupt flag, bits [27:24] the engine and bits [15:0] the size. Word 3 holds the head address. An entry is dispatched only when (timestamp − PTS) has bit 31 clear, and exec_req stays high until exec_done.
- R5: When the last descriptor of an entry completes, that queue's head advances by one, modulo N.
- R6: Among due entries the general queue is served first, then plane 0, plane 1 and plane 2.
- R7: For a general entry, word 4 (control) and word 5 (head) form a second descriptor. It is dispatched after the first completes, and only if its size field is non-zero.
- R8: With the preempt bit (control bit 1) set, an in-flight entry finishes, busy then falls, and no new dispatch starts until preempt clears.
- R9: A wake command (csr_sel=2) starts a scan within a few cycles. Without a wake, a scan still occurs every POLL_CYCLES cycles.
- R10: The fast queue never dispatches and its head never moves.
- R11: A clear command (csr_sel=3) zeroes the control bits, every head and every tail.
- R12: With the enable bit (control bit 0) clear, nothing is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_we | input | 1 | Entry RAM write strobe |
| ram_addr | input | 10 | Entry RAM word address |
| ram_wdata | input | 32 | Entry RAM write data |
| csr_we | input | 1 | Command write strobe |
| csr_sel | input | 2 | 0 control, 1 tails, 2 wake, 3 clear |
| csr_wdata | input | 32 | Command data |
| ctrl_o | output | 2 | Control bits {preempt, enable} |
| busy | output | 1 | Engine is working on a scan or an entry |
| ts_o | output | TS_W | Free-running timestamp |
| heads_o | output | 18 | Packed head pointers |
| tails_o | output | 18 | Packed tail pointers |
| full_o | output | 5 | Per-queue full flags |
| exec_req | output | 1 | Descriptor valid, held until done |
| exec_done | input | 1 | Execution port completion pulse |
| exec_head | output | 32 | Descriptor buffer head address |
| exec_engine | output | 4 | Descriptor engine number |
| exec_size | output | 16 | Descriptor size in 64-byte units |
| exec_irq | output | 1 | Descriptor interrupt flag |

## Verification
The bench aims at timestamp wraparound. A PTS set more than half the range ahead must count as already past, and a design that compared magnitudes instead would stall that entry. It loads all four dispatching queues while preempted and then releases them. This exposes a wrong priority order, or a second general descriptor that is skipped or sent with a zero size. It also sets preempt in the middle of a dispatch, where a design that dropped the entry, or started the next one, would show up in the descriptor count and in busy. It checks that the fast queue stays put, that tail writes leave heads alone, and that random traffic wraps the ring pointers correctly.

// File: rtl/flipq_pkg.sv
package flipq_pkg;
    localparam int NQ     = 5;
    localparam int DW     = 32;
    localparam int AW     = 10;
    localparam int DEPTH  = 1 << AW;
    localparam int PW     = 4;
    localparam int TAIL_W = 18;
    localparam int Q_GEN  = 3;
    localparam int Q_FAST = 4;

    localparam int IRQ_BIT = 31;
    localparam int ENG_LO  = 24;
    localparam int ENG_W   = 4;
    localparam int SIZE_W  = 16;

    localparam int W_PTS   = 0;
    localparam int W_CTL   = 2;
    localparam int W_HEAD  = 3;
    localparam int W_CTL2  = 4;
    localparam int W_HEAD2 = 5;

    typedef logic [PW-1:0] ptr_t;
    typedef logic [AW-1:0] waddr_t;

    typedef struct packed {
        logic              irq;
        logic [ENG_W-1:0]  engine;
        logic [SIZE_W-1:0] size;
        logic [DW-1:0]     head;
    } desc_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PICK, S_CHK, S_CTL, S_HD, S_WAIT, S_C2, S_C2D, S_H2
    } st_t;

    function automatic waddr_t q_base(int q);
        case (q)
            0:       return waddr_t'(10'h008);
            1:       return waddr_t'(10'h108);
            2:       return waddr_t'(10'h208);
            3:       return waddr_t'(10'h308);
            default: return waddr_t'(10'h3C8);
        endcase
    endfunction

    function automatic int q_esz(int q);
        return (q < Q_GEN) ? 4 : 6;
    endfunction

    function automatic int q_ents(int q);
        return (q < Q_GEN) ? 16 : 8;
    endfunction

    function automatic int q_pw(int q);
        return (q < Q_GEN) ? 4 : 3;
    endfunction

    function automatic int q_tlo(int q);
        return (q < Q_FAST) ? 4 * q : 15;
    endfunction

    function automatic ptr_t q_mask(int q);
        return ptr_t'(q_ents(q) - 1);
    endfunction

    function automatic ptr_t field_get(logic [TAIL_W-1:0] v, int q);
        return ptr_t'(v >> q_tlo(q)) & q_mask(q);
    endfunction

    function automatic logic [2:0] order_q(logic [2:0] idx);
        return (idx == 3'd0) ? 3'(Q_GEN) : idx - 3'd1;
    endfunction
endpackage

// File: rtl/flipq_ram.sv
module flipq_ram #(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/flipq_ptrs.sv
module flipq_ptrs
    import flipq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                tail_we,
    input  logic [TAIL_W-1:0]   tail_wdata,
    input  logic                adv,
    input  logic [2:0]          adv_q,
    output ptr_t [NQ-1:0]       heads,
    output ptr_t [NQ-1:0]       tails,
    output logic [NQ-1:0]       empty,
    output logic [NQ-1:0]       full
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            heads <= '0;
            tails <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (tail_we)
                    tails[q] <= field_get(tail_wdata, q);
                if (adv && int'(adv_q) == q)
                    heads[q] <= (heads[q] + ptr_t'(1)) & q_mask(q);
            end
        end
    end

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            empty[q] = (heads[q] == tails[q]);
            full[q]  = ((tails[q] - heads[q]) & q_mask(q)) == q_mask(q);
        end
    end
endmodule

// File: rtl/flipq_sched.sv
module flipq_sched
    import flipq_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            enable,
    input  logic            preempt,
    input  logic            scan_go,
    input  logic [TS_W-1:0] ts,
    input  ptr_t [NQ-1:0]   heads,
    input  logic [NQ-1:0]   empty,
    input  logic [DW-1:0]   rd_data,
    output waddr_t          rd_addr,
    output logic            scan_ack,
    output logic            busy,
    output logic            adv,
    output logic [2:0]      adv_q,
    output logic            second,
    output logic            exec_req,
    input  logic            exec_done,
    output desc_t           desc
);
    st_t        st;
    logic [2:0] qi;
    logic [2:0] cq;
    logic [2:0] q_sel;
    logic [2:0] wsel;
    waddr_t     hoff;
    logic [TS_W-1:0] diff;
    logic       due;
    logic       size_zero;
    logic       gen_first;
    logic       unused_bits;

    assign unused_bits = ^{rd_data[30:28], rd_data[23:16]};

    always_comb begin
        q_sel = (st == S_PICK) ? order_q(qi) : cq;
        case (st)
            S_CHK:   wsel = 3'(W_CTL);
            S_CTL:   wsel = 3'(W_HEAD);
            S_C2:    wsel = 3'(W_CTL2);
            S_C2D:   wsel = 3'(W_HEAD2);
            default: wsel = 3'(W_PTS);
        endcase
        hoff    = waddr_t'(heads[q_sel]) * waddr_t'(q_esz(int'(q_sel)));
        rd_addr = q_base(int'(q_sel)) + hoff + waddr_t'(wsel);
    end

    assign diff      = ts - rd_data[TS_W-1:0];
    assign due       = !diff[TS_W-1];
    assign size_zero = (rd_data[SIZE_W-1:0] == '0);
    assign gen_first = (cq == 3'(Q_GEN)) && !second;
    assign scan_ack  = (st == S_IDLE) && enable && !preempt && scan_go;
    assign busy      = (st != S_IDLE);
    assign adv_q     = cq;
    assign adv       = ((st == S_WAIT) && exec_done && !gen_first) ||
                       ((st == S_C2D) && size_zero);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st       <= S_IDLE;
            qi       <= '0;
            cq       <= '0;
            second   <= 1'b0;
            exec_req <= 1'b0;
            desc     <= '0;
        end else begin
            case (st)
                S_IDLE: if (scan_ack) begin
                    qi <= '0;
                    st <= S_PICK;
                end
                S_PICK: begin
                    if (preempt || qi == 3'd4)
                        st <= S_IDLE;
                    else if (!empty[order_q(qi)]) begin
                        cq <= order_q(qi);
                        st <= S_CHK;
                    end else
                        qi <= qi + 3'd1;
                end
                S_CHK: begin
                    if (preempt)
                        st <= S_IDLE;
                    else if (due)
                        st <= S_CTL;
                    else begin
                        qi <= qi + 3'd1;
                        st <= S_PICK;
                    end
                end
                S_CTL: begin
                    desc.irq    <= rd_data[IRQ_BIT];
                    desc.engine <= rd_data[ENG_LO +: ENG_W];
                    desc.size   <= rd_data[SIZE_W-1:0];
                    second      <= 1'b0;
                    st          <= S_HD;
                end
                S_HD, S_H2: begin
                    desc.head <= rd_data;
                    exec_req  <= 1'b1;
                    st        <= S_WAIT;
                end
                S_WAIT: if (exec_done) begin
                    exec_req <= 1'b0;
                    if (gen_first)
                        st <= S_C2;
                    else begin
                        qi <= '0;
                        st <= S_PICK;
                    end
                end
                S_C2: st <= S_C2D;
                S_C2D: begin
                    if (size_zero) begin
                        qi <= '0;
                        st <= S_PICK;
                    end else begin
                        desc.irq    <= rd_data[IRQ_BIT];
                        desc.engine <= rd_data[ENG_LO +: ENG_W];
                        desc.size   <= rd_data[SIZE_W-1:0];
                        second      <= 1'b1;
                        st          <= S_H2;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flipq_engine.sv
module flipq_engine
    import flipq_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int POLL_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ram_we,
    input  logic [AW-1:0]     ram_addr,
    input  logic [DW-1:0]     ram_wdata,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [DW-1:0]     csr_wdata,
    output logic [1:0]        ctrl_o,
    output logic              busy,
    output logic [TS_W-1:0]   ts_o,
    output logic [TAIL_W-1:0] heads_o,
    output logic [TAIL_W-1:0] tails_o,
    output logic [NQ-1:0]     full_o,
    output logic              exec_req,
    input  logic              exec_done,
    output logic [DW-1:0]     exec_head,
    output logic [ENG_W-1:0]  exec_engine,
    output logic [SIZE_W-1:0] exec_size,
    output logic              exec_irq
);
    localparam int PCW = $clog2(POLL_CYCLES);

    logic            ctrl_en, ctrl_pre;
    logic            csr_ctrl, csr_tail, csr_wake, csr_clr;
    logic [TS_W-1:0] ts;
    logic [PCW-1:0]  poll_cnt;
    logic            poll_tick, scan_pend, scan_ack;
    ptr_t [NQ-1:0]   heads, tails;
    logic [NQ-1:0]   empty;
    logic [DW-1:0]   rd_data;
    waddr_t          rd_addr;
    logic            adv, second;
    logic [2:0]      adv_q;
    desc_t           desc;
    logic            unused_top;

    assign csr_ctrl  = csr_we && csr_sel == 2'd0;
    assign csr_tail  = csr_we && csr_sel == 2'd1;
    assign csr_wake  = csr_we && csr_sel == 2'd2;
    assign csr_clr   = csr_we && csr_sel == 2'd3;
    assign poll_tick = (poll_cnt == PCW'(POLL_CYCLES - 1));
    assign unused_top = ^{csr_wdata[DW-1:TAIL_W], heads[Q_GEN][PW-1], heads[Q_FAST][PW-1],
                          tails[Q_GEN][PW-1], tails[Q_FAST][PW-1], second};

    always_ff @(posedge clk) begin
        if (rst) begin
            ts       <= '0;
            poll_cnt <= '0;
        end else begin
            ts       <= ts + 1'b1;
            poll_cnt <= poll_tick ? '0 : poll_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || csr_clr) begin
            ctrl_en   <= 1'b0;
            ctrl_pre  <= 1'b0;
            scan_pend <= 1'b0;
        end else begin
            if (csr_ctrl) begin
                ctrl_en  <= csr_wdata[0];
                ctrl_pre <= csr_wdata[1];
            end
            if (poll_tick || csr_wake)
                scan_pend <= 1'b1;
            else if (scan_ack)
                scan_pend <= 1'b0;
        end
    end

    flipq_ram #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    flipq_ptrs u_ptrs (
        .clk(clk), .rst(rst), .clr(csr_clr), .tail_we(csr_tail),
        .tail_wdata(csr_wdata[TAIL_W-1:0]), .adv(adv), .adv_q(adv_q),
        .heads(heads), .tails(tails), .empty(empty), .full(full_o)
    );

    flipq_sched #(.TS_W(TS_W)) u_sched (
        .clk(clk), .rst(rst), .clr(csr_clr), .enable(ctrl_en), .preempt(ctrl_pre),
        .scan_go(scan_pend), .ts(ts), .heads(heads), .empty(empty),
        .rd_data(rd_data), .rd_addr(rd_addr), .scan_ack(scan_ack), .busy(busy),
        .adv(adv), .adv_q(adv_q), .second(second), .exec_req(exec_req),
        .exec_done(exec_done), .desc(desc)
    );

    always_comb begin
        heads_o = '0;
        tails_o = '0;
        for (int q = 0; q < NQ; q++) begin
            for (int b = 0; b < PW; b++) begin
                if (b < q_pw(q)) begin
                    heads_o[q_tlo(q) + b] = heads[q][b];
                    tails_o[q_tlo(q) + b] = tails[q][b];
                end
            end
        end
    end

    assign ctrl_o      = {ctrl_pre, ctrl_en};
    assign ts_o        = ts;
    assign exec_head   = desc.head;
    assign exec_engine = desc.engine;
    assign exec_size   = desc.size;
    assign exec_irq    = desc.irq;
endmodule

// File: rtl/flipq_engine_chk.sv
module flipq_engine_chk
    import flipq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              csr_clr,
    input logic              csr_tail,
    input logic              adv,
    input logic              preempt,
    input logic              busy,
    input logic              exec_req,
    input logic              exec_done,
    input logic [1:0]        ctrl_o,
    input logic [TAIL_W-1:0] heads_o,
    input logic [TAIL_W-1:0] tails_o
);
    // R5
    head_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(heads_o) |-> ($past(adv) || $past(csr_clr)));

    // R2
    tail_keeps_head_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_tail && !adv) |=> $stable(heads_o));

    // R11
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        csr_clr |=> (heads_o == '0 && tails_o == '0 && ctrl_o == 2'b00));

    // R8
    preempt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (preempt && !busy) |=> !busy);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_req && !exec_done && !csr_clr) |=> exec_req);

    // R10
    fast_still_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_clr |=> $stable(heads_o[TAIL_W-1:15]));
endmodule

bind flipq_engine flipq_engine_chk u_chk (
    .clk(clk), .rst(rst), .csr_clr(csr_clr), .csr_tail(csr_tail), .adv(adv),
    .preempt(ctrl_pre), .busy(busy), .exec_req(exec_req), .exec_done(exec_done),
    .ctrl_o(ctrl_o), .heads_o(heads_o), .tails_o(tails_o)
);

// File: tb/flipq_engine_test.sv
module flipq_engine_test;
    localparam int POLL = 1500;

    logic        clk = 0, rst = 1;
    logic        ram_we = 0;
    logic [9:0]  ram_addr = '0;
    logic [31:0] ram_wdata = '0;
    logic        csr_we = 0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  ctrl_o;
    logic        busy;
    logic [31:0] ts_o;
    logic [17:0] heads_o, tails_o;
    logic [4:0]  full_o;
    logic        exec_req, exec_done = 0, exec_irq;
    logic [31:0] exec_head;
    logic [3:0]  exec_engine;
    logic [15:0] exec_size;

    flipq_engine #(.TS_W(32), .POLL_CYCLES(POLL)) uut (.*);

    always #4 clk = ~clk;

    int n_run = 0, n_fail = 0;
    int n_got = 0;
    int resp_delay = 2;
    logic [52:0] got_d [128];
    logic [31:0] got_ts [128];
    int btail [5];
    int bhead [5];

    function automatic int b_base(int q);
        case (q) 0: return 'h008; 1: return 'h108; 2: return 'h208; 3: return 'h308; default: return 'h3C8; endcase
    endfunction
    function automatic int b_esz(int q);  return q < 3 ? 4 : 6;  endfunction
    function automatic int b_ents(int q); return q < 3 ? 16 : 8; endfunction
    function automatic logic [17:0] pack(int p0, int p1, int p2, int g, int f);
        return {3'(f), 3'(g), 4'(p2), 4'(p1), 4'(p0)};
    endfunction
    function automatic logic [31:0] mk_ctl(logic irq, logic [3:0] eng, logic [15:0] sz);
        return {irq, 3'b000, eng, 8'h00, sz};
    endfunction
    function automatic logic [52:0] exp_desc(logic [31:0] ctl, logic [31:0] hd);
        return {ctl[31], ctl[27:24], ctl[15:0], hd};
    endfunction

    // execution port model
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (exec_req && !exec_done) begin
                cnt++;
                if (cnt >= resp_delay) begin exec_done = 1; cnt = 0; end
            end else exec_done = 0;
        end
    end

    // descriptor monitor
    initial begin
        logic prev = 0;
        forever begin
            @(negedge clk);
            if (exec_req && !prev && n_got < 128) begin
                got_d[n_got]  = {exec_irq, exec_engine, exec_size, exec_head};
                got_ts[n_got] = ts_o;
                n_got++;
            end
            prev = exec_req;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

    task automatic csr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); csr_we = 1; csr_sel = s; csr_wdata = d;
        @(negedge clk); csr_we = 0;
    endtask

    task automatic ram_wr(input int a, input logic [31:0] d);
        @(negedge clk); ram_we = 1; ram_addr = 10'(a); ram_wdata = d;
        @(negedge clk); ram_we = 0;
    endtask

    task automatic put_entry(input int q, input logic [31:0] pts, input logic [31:0] c1,
                             input logic [31:0] h1, input logic [31:0] c2, input logic [31:0] h2);
        int a = b_base(q) + btail[q] * b_esz(q);
        ram_wr(a, pts); ram_wr(a + 1, 0); ram_wr(a + 2, c1); ram_wr(a + 3, h1);
        if (b_esz(q) == 6) begin ram_wr(a + 4, c2); ram_wr(a + 5, h2); end
        btail[q] = (btail[q] + 1) % b_ents(q);
    endtask

    task automatic publish(); csr(2'd1, 32'(pack(btail[0], btail[1], btail[2], btail[3], btail[4]))); endtask
    task automatic wake(); csr(2'd2, 0); endtask
    task automatic bump(input int q); bhead[q] = (bhead[q] + 1) % b_ents(q); endtask

    task automatic wait_n(input int n, input int maxc);
        for (int i = 0; i < maxc && n_got < n; i++) @(negedge clk);
    endtask

    task automatic chk_heads(input string tag);
        logic [17:0] e = pack(bhead[0], bhead[1], bhead[2], bhead[3], bhead[4]);
        check(heads_o == e, tag, heads_o, e);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n0;
        logic [31:0] pts, c1, h1, c2, h2;
        logic [31:0] cg1, hg1, cg2, hg2, cp0, cp1, cp2;
        void'($urandom(32'd1234));
        for (int q = 0; q < 5; q++) begin btail[q] = 0; bhead[q] = 0; end
        cyc(3); rst = 0; cyc(2);

        // R1 reset state
        check(heads_o == 0 && tails_o == 0, "R1 pointers", {heads_o, tails_o}, 0);
        check(ctrl_o == 0 && full_o == 0 && !busy && !exec_req, "R1 status",
              {ctrl_o, full_o, busy, exec_req}, 0);

        // R2 / R3 packed tails with engine disabled
        csr(2'd1, 32'(pack(5, 9, 15, 7, 3)));
        cyc(1);
        check(tails_o == pack(5, 9, 15, 7, 3), "R2 tail fields", tails_o, pack(5, 9, 15, 7, 3));
        check(heads_o == 0, "R2 heads untouched", heads_o, 0);
        check(full_o == 5'b01100, "R3 full flags", full_o, 5'b01100);
        // R12 disabled: no dispatch across poll periods
        cyc(2 * POLL + 20);
        check(n_got == 0, "R12 disabled no dispatch", n_got, 0);
        // R11 clear
        csr(2'd0, 32'd2);
        csr(2'd3, 0);
        cyc(1);
        check(tails_o == 0 && heads_o == 0 && ctrl_o == 0, "R11 clear", {ctrl_o, tails_o, heads_o}, 0);

        // R9 / R4 wake-driven dispatch of a plane entry
        csr(2'd0, 32'd1);
        cyc(POLL + 20);
        n0 = n_got;
        c1 = mk_ctl(1, 4'h5, 16'h0123); h1 = 32'hABCD_0000;
        put_entry(0, ts_o - 5, c1, h1, 0, 0);
        publish(); wake();
        cyc(12);
        check(n_got == n0 + 1, "R9 wake dispatch", n_got, n0 + 1);
        check(got_d[n0] == exp_desc(c1, h1), "R4 descriptor fields", got_d[n0], exp_desc(c1, h1));
        cyc(8); bump(0);
        chk_heads("R5 head advance");

        // R4 not yet due, then dispatched by periodic poll (R9)
        n0 = n_got;
        pts = ts_o + 300;
        c1 = mk_ctl(0, 4'h2, 16'h0040); h1 = 32'h1111_2222;
        put_entry(1, pts, c1, h1, 0, 0);
        publish(); wake(); cyc(20);
        check(n_got == n0, "R4 early entry held", n_got, n0);
        wait_n(n0 + 1, 2 * POLL + 50);
        check(n_got == n0 + 1, "R9 poll dispatch", n_got, n0 + 1);
        check(!(got_ts[n0] - pts) >> 31 == 1 || ((got_ts[n0] - pts) >> 31) == 0,
              "R4 dispatched when due", got_ts[n0], pts);
        cyc(8); bump(1);

        // R4 wraparound: PTS more than half range ahead counts as past
        n0 = n_got;
        c1 = mk_ctl(0, 4'h7, 16'h0002); h1 = 32'h0BAD_F00D;
        put_entry(2, ts_o + 32'h8000_0000 + 32'd40, c1, h1, 0, 0);
        publish(); wake(); cyc(12);
        check(n_got == n0 + 1 && got_d[n0] == exp_desc(c1, h1), "R4 wraparound due", got_d[n0], exp_desc(c1, h1));
        cyc(8); bump(2);

        // R6 / R7 / R8 priority after preempt release
        csr(2'd0, 32'd3);
        n0 = n_got;
        pts = ts_o - 20;
        cp2 = mk_ctl(0, 4'h3, 16'h0003); cp1 = mk_ctl(1, 4'h2, 16'h0002); cp0 = mk_ctl(0, 4'h1, 16'h0001);
        cg1 = mk_ctl(1, 4'h8, 16'h0010); hg1 = 32'hC000_0001;
        cg2 = mk_ctl(0, 4'h9, 16'h0020); hg2 = 32'hC000_0002;
        put_entry(2, pts, cp2, 32'hA000_0002, 0, 0);
        put_entry(1, pts, cp1, 32'hA000_0001, 0, 0);
        put_entry(3, pts, cg1, hg1, cg2, hg2);
        put_entry(0, pts, cp0, 32'hA000_0000, 0, 0);
        publish(); wake(); cyc(50);
        check(n_got == n0 && !busy, "R8 preempt blocks dispatch", {n_got, busy}, {n0, 1'b0});
        csr(2'd0, 32'd1); wake();
        wait_n(n0 + 5, 200);
        check(got_d[n0] == exp_desc(cg1, hg1), "R6 general first", got_d[n0], exp_desc(cg1, hg1));
        check(got_d[n0 + 1] == exp_desc(cg2, hg2), "R7 second descriptor", got_d[n0 + 1], exp_desc(cg2, hg2));
        check(got_d[n0 + 2] == exp_desc(cp0, 32'hA000_0000), "R6 plane0 next", got_d[n0 + 2], exp_desc(cp0, 32'hA000_0000));
        check(got_d[n0 + 3] == exp_desc(cp1, 32'hA000_0001), "R6 plane1 next", got_d[n0 + 3], exp_desc(cp1, 32'hA000_0001));
        check(got_d[n0 + 4] == exp_desc(cp2, 32'hA000_0002), "R6 plane2 last", got_d[n0 + 4], exp_desc(cp2, 32'hA000_0002));
        cyc(10); bump(0); bump(1); bump(2); bump(3);
        chk_heads("R5 heads after batch");

        // R7 zero-size second descriptor is skipped
        n0 = n_got;
        put_entry(3, ts_o - 3, cg1, hg1, mk_ctl(1, 4'hF, 16'h0000), 32'hDEAD_BEEF);
        publish(); wake(); cyc(100);
        check(n_got == n0 + 1, "R7 single descriptor", n_got, n0 + 1);
        bump(3);
        chk_heads("R7 head advanced");

        // R8 preempt during an in-flight dispatch
        resp_delay = 30;
        n0 = n_got;
        c1 = mk_ctl(0, 4'h4, 16'h0004); h1 = 32'h5555_0000;
        put_entry(0, ts_o - 3, c1, h1, 0, 0);
        publish(); wake();
        for (int i = 0; i < 40 && !exec_req; i++) @(negedge clk);
        csr(2'd0, 32'd3);
        check(busy == 1, "R8 busy while in flight", busy, 1);
        put_entry(1, ts_o - 3, mk_ctl(0, 4'h6, 16'h0006), 32'h6666_0000, 0, 0);
        publish(); wake();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        cyc(100);
        check(!busy && n_got == n0 + 1, "R8 finish then idle", {busy, n_got}, {1'b0, n0 + 1});
        resp_delay = 2;
        csr(2'd0, 32'd1); wake();
        wait_n(n0 + 2, 50);
        check(got_d[n0 + 1] == exp_desc(mk_ctl(0, 4'h6, 16'h0006), 32'h6666_0000), "R8 resumes",
              got_d[n0 + 1], exp_desc(mk_ctl(0, 4'h6, 16'h0006), 32'h6666_0000));
        cyc(10); bump(0); bump(1);

        // R10 fast queue never dispatches
        n0 = n_got;
        put_entry(4, ts_o - 3, mk_ctl(1, 4'h1, 16'h0001), 32'h7777_0000, 0, 0);
        publish(); wake(); cyc(100);
        check(n_got == n0 && heads_o[17:15] == 0 && tails_o[17:15] == 1, "R10 fast idle",
              {n_got, heads_o[17:15]}, {n0, 3'd0});

        // random traffic, wraps ring pointers (R5, R4, R7)
        for (int it = 0; it < 40; it++) begin
            int q = int'($urandom % 4);
            int ne;
            c1 = mk_ctl(1'($urandom), 4'($urandom), 16'($urandom % 65535 + 1));
            h1 = $urandom;
            c2 = ((q == 3) && ($urandom % 2 == 1)) ? mk_ctl(1'($urandom), 4'($urandom), 16'($urandom % 100 + 1)) : 32'h0;
            h2 = $urandom;
            ne = (c2[15:0] != 0) ? 2 : 1;
            n0 = n_got;
            put_entry(q, ts_o - ($urandom % 1000 + 1), c1, h1, c2, h2);
            publish(); wake();
            wait_n(n0 + ne, 100);
            check(got_d[n0] == exp_desc(c1, h1), "R4 random descriptor", got_d[n0], exp_desc(c1, h1));
            if (ne == 2)
                check(got_d[n0 + 1] == exp_desc(c2, h2), "R7 random second", got_d[n0 + 1], exp_desc(c2, h2));
            cyc(10); bump(q);
            chk_heads("R5 random heads");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule